// File: doc/BRIEF.md
# Protected Flash Command Sequence Decoder

This block is the device-side write path of a parallel flash model. It watches the chip enable, write enable and output enable pins, together with the address and data buses. It turns each valid, long enough write strobe into one bus write. The block then checks these writes against the unlock-and-command handshakes that have to come before any program or erase. A program needs three command writes followed by the data write. An erase needs six writes, and the last one carries the erase kind. Any write that does not fit the expected step sends the decoder back to read mode. The protection cannot be turned off.

When a sequence completes, the block sends a one-cycle command pulse to a separate array model. The pulse carries the operation kind, the address and the data. The block then stays busy for a cycle count set per operation kind. While it is busy, a read shows polling status instead of array data: bit 7 is the inverted programmed bit 7, or 0 for an erase, and bit 6 toggles on every read. The supply-good indication comes in as a plain input.

Top module: `flash_cmd_seq`

## Requirements
- R1: A program is accepted only after the writes 0xAA at 0x5555, 0x55 at 0x2AAA and 0xA0 at 0x5555, with the addresses compared on the low CMP_W bits. The next write is then reported on `cmd_valid` with `cmd_op`=0 and that write's full address and 16-bit data. `cmd_valid` rises two clock edges after the sampled strobe release.
- R2: An erase is accepted only after 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and then a final code. The final code 0x10@0x5555 gives `cmd_op`=3 (chip). The code 0x30 at any address gives `cmd_op`=1 (sector). The code 0x50 at any address gives `cmd_op`=2 (block). `cmd_addr` reports the final write's address.
- R3: A write that does not match the expected step returns the decoder to the idle step, and that write is itself discarded. Writes that would have continued the broken sequence then produce no command.
- R4: A write happens only while `ce_n` and `we_n` are both low and `oe_n` is high. `oe_n` low cancels the strobe in progress.
- R5: A strobe seen low on fewer than MIN_LOW_CYC clock edges produces no write. A write takes its address and data from the last low cycle and is latched when the strobe is released.
- R6: While `supply_ok` is low, no write is produced, and a strobe in progress is cancelled.
- R7: Only data bits 7:0 are decoded during command writes. Bits 15:8 have no effect.
- R8: `busy` rises one cycle after `cmd_valid`. It stays high for PROG_BUSY, SECT_BUSY, BLK_BUSY or CHIP_BUSY cycles according to the operation. Writes that arrive while `busy` is high are ignored.
- R9: While `busy` is high, `rdata[7]` is the inverse of the programmed data bit 7 for a program, and 0 for any erase.
- R10: While `busy` is high, `rdata[6]` is 0 on the first read after a command and inverts after each `rd_en` cycle. All other bits, and all bits when not busy, equal `array_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| supply_ok | input | 1 | High when the supply is above the write threshold |
| addr | input | ADDR_W | Bus address |
| wdata | input | 16 | Bus write data |
| rd_en | input | 1 | One cycle per read access |
| array_rdata | input | 16 | True data from the array model |
| rdata | output | 16 | Read data, with status while busy |
| busy | output | 1 | Internal operation in progress |
| cmd_valid | output | 1 | One-cycle accepted-command pulse |
| cmd_op | output | 2 | 0 program, 1 sector, 2 block, 3 chip erase |
| cmd_addr | output | ADDR_W | Address of the accepting write |
| cmd_data | output | 16 | Data of the accepting write |

## Verification
A sequence step register that is stuck or skips a step shows up at the ports as a missing or extra `cmd_valid` two edges after the final strobe release. It also shows up later, when a fresh full sequence run after an aborted one fails to produce exactly one command. A wrong strobe count is visible as a glitch write that changes the outcome of the next sequence. A wrong busy count or status register is visible within one cycle in `busy` run length, in `rdata[7]` and in `rdata[6]`, on reads during the operation and on the first read after it.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } fsq_op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_U1, S_U2, S_PG, S_E1, S_E2, S_E3
    } fsq_state_e;

    localparam logic [15:0] UNLOCK_A1 = 16'h5555;
    localparam logic [15:0] UNLOCK_A2 = 16'h2AAA;
    localparam logic [7:0]  KEY1      = 8'hAA;
    localparam logic [7:0]  KEY2      = 8'h55;
    localparam logic [7:0]  CODE_PROG = 8'hA0;
    localparam logic [7:0]  CODE_ERS  = 8'h80;
    localparam logic [7:0]  CODE_CHIP = 8'h10;
    localparam logic [7:0]  CODE_SECT = 8'h30;
    localparam logic [7:0]  CODE_BLK  = 8'h50;
endpackage

// File: rtl/fsq_strobe_filter.sv
module fsq_strobe_filter #(
    parameter int ADDR_W      = 20,
    parameter int MIN_LOW_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              supply_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic              wr_vld,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data
);
    localparam int CW = $clog2(MIN_LOW_CYC + 1);
    localparam logic [CW-1:0] CNT_MIN = CW'(MIN_LOW_CYC);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       data;
        logic              vld;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d     = flt_q;
        flt_d.vld = 1'b0;
        if (!supply_ok || !oe_n) begin
            flt_d.cnt = '0;
        end else if (!ce_n && !we_n) begin
            if (flt_q.cnt < CNT_MIN) flt_d.cnt = flt_q.cnt + 1'b1;
            flt_d.addr = addr;
            flt_d.data = wdata;
        end else begin
            flt_d.vld = (flt_q.cnt >= CNT_MIN);
            flt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign wr_vld  = flt_q.vld;
    assign wr_addr = flt_q.addr;
    assign wr_data = flt_q.data;

    assert_oe_inhibit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |=> !wr_vld);
    assert_supply_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !wr_vld);
    assert_long_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |-> ($past(flt_q.cnt) >= CNT_MIN));
endmodule

// File: rtl/fsq_seq_fsm.sv
module fsq_seq_fsm
    import fsq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CMP_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              busy,
    output logic              cmd_valid,
    output fsq_op_e           cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [15:0]       cmd_data
);
    localparam logic [CMP_W-1:0] A1 = CMP_W'(UNLOCK_A1);
    localparam logic [CMP_W-1:0] A2 = CMP_W'(UNLOCK_A2);

    typedef struct packed {
        fsq_state_e        st;
        logic              vld;
        fsq_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       data;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [7:0] lo_byte;
    logic       at_a1, at_a2;

    assign lo_byte = wr_data[7:0];
    assign at_a1   = (wr_addr[CMP_W-1:0] == A1);
    assign at_a2   = (wr_addr[CMP_W-1:0] == A2);

    always_comb begin
        seq_d     = seq_q;
        seq_d.vld = 1'b0;
        if (wr_vld && !busy) begin
            seq_d.st = S_IDLE;
            unique case (seq_q.st)
                S_IDLE: if (at_a1 && lo_byte == KEY1) seq_d.st = S_U1;
                S_U1:   if (at_a2 && lo_byte == KEY2) seq_d.st = S_U2;
                S_U2: begin
                    if (at_a1 && lo_byte == CODE_PROG)     seq_d.st = S_PG;
                    else if (at_a1 && lo_byte == CODE_ERS) seq_d.st = S_E1;
                end
                S_PG: begin
                    seq_d.vld  = 1'b1;
                    seq_d.op   = OP_PROG;
                    seq_d.addr = wr_addr;
                    seq_d.data = wr_data;
                end
                S_E1:   if (at_a1 && lo_byte == KEY1) seq_d.st = S_E2;
                S_E2:   if (at_a2 && lo_byte == KEY2) seq_d.st = S_E3;
                S_E3: begin
                    seq_d.addr = wr_addr;
                    seq_d.data = wr_data;
                    if (at_a1 && lo_byte == CODE_CHIP) begin
                        seq_d.vld = 1'b1;
                        seq_d.op  = OP_CHIP;
                    end else if (lo_byte == CODE_SECT) begin
                        seq_d.vld = 1'b1;
                        seq_d.op  = OP_SECT;
                    end else if (lo_byte == CODE_BLK) begin
                        seq_d.vld = 1'b1;
                        seq_d.op  = OP_BLK;
                    end
                end
                default: seq_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= S_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_valid = seq_q.vld;
    assign cmd_op    = seq_q.op;
    assign cmd_addr  = seq_q.addr;
    assign cmd_data  = seq_q.data;

    assert_accept_needs_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(wr_vld));
    assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && busy) |=> !cmd_valid);
    assert_erase_from_final_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != OP_PROG) |-> $past(seq_q.st) == S_E3);
endmodule

// File: rtl/fsq_status_gen.sv
module fsq_status_gen
    import fsq_pkg::*;
#(
    parameter int BUSY_W    = 16,
    parameter int PROG_BUSY = 20,
    parameter int SECT_BUSY = 40,
    parameter int BLK_BUSY  = 60,
    parameter int CHIP_BUSY = 80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  fsq_op_e     start_op,
    input  logic        start_d7,
    input  logic        rd_en,
    input  logic [15:0] array_rdata,
    output logic        busy,
    output logic [15:0] rdata
);
    typedef struct packed {
        logic [BUSY_W-1:0] cnt;
        logic              erase;
        logic              d7;
        logic              tog;
    } st_t;

    st_t st_d, st_q;
    logic [BUSY_W-1:0] load_val;

    always_comb begin
        unique case (start_op)
            OP_PROG: load_val = BUSY_W'(PROG_BUSY);
            OP_SECT: load_val = BUSY_W'(SECT_BUSY);
            OP_BLK:  load_val = BUSY_W'(BLK_BUSY);
            default: load_val = BUSY_W'(CHIP_BUSY);
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt   = load_val;
            st_d.erase = (start_op != OP_PROG);
            st_d.d7    = start_d7;
            st_d.tog   = 1'b0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (rd_en) st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);

    always_comb begin
        rdata = array_rdata;
        if (busy) begin
            rdata[7] = st_q.erase ? 1'b0 : ~st_q.d7;
            rdata[6] = st_q.tog;
        end
    end

    assert_start_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    assert_toggle_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en && !start && st_q.cnt != BUSY_W'(1)) |=> rdata[6] != $past(rdata[6]));
    assert_erase_poll_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.erase) |-> !rdata[7]);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fsq_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int CMP_W       = 15,
    parameter int MIN_LOW_CYC = 2,
    parameter int BUSY_W      = 16,
    parameter int PROG_BUSY   = 20,
    parameter int SECT_BUSY   = 40,
    parameter int BLK_BUSY    = 60,
    parameter int CHIP_BUSY   = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              supply_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              rd_en,
    input  logic [15:0]       array_rdata,
    output logic [15:0]       rdata,
    output logic              busy,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [15:0]       cmd_data
);
    logic              wr_vld;
    logic [ADDR_W-1:0] wr_addr;
    logic [15:0]       wr_data;
    fsq_op_e           op;

    fsq_strobe_filter #(.ADDR_W(ADDR_W), .MIN_LOW_CYC(MIN_LOW_CYC)) u_filter (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .supply_ok(supply_ok), .addr(addr), .wdata(wdata),
        .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    fsq_seq_fsm #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .cmd_valid(cmd_valid),
        .cmd_op(op), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    fsq_status_gen #(
        .BUSY_W(BUSY_W), .PROG_BUSY(PROG_BUSY), .SECT_BUSY(SECT_BUSY),
        .BLK_BUSY(BLK_BUSY), .CHIP_BUSY(CHIP_BUSY)
    ) u_status (
        .clk(clk), .rst_n(rst_n), .start(cmd_valid), .start_op(op),
        .start_d7(cmd_data[7]), .rd_en(rd_en), .array_rdata(array_rdata),
        .busy(busy), .rdata(rdata)
    );

    assign cmd_op = op;

    assert_pulse_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    localparam int PROG_BUSY = 20;
    localparam int SECT_BUSY = 40;
    localparam int BLK_BUSY  = 60;
    localparam int CHIP_BUSY = 80;
    localparam logic [15:0] ARR = 16'hA5C3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, supply_ok = 1'b1, rd_en = 1'b0;
    logic [19:0] addr = '0;
    logic [15:0] wdata = '0, array_rdata = ARR;
    logic [15:0] rdata, cmd_data;
    logic        busy, cmd_valid;
    logic [1:0]  cmd_op;
    logic [19:0] cmd_addr;

    int nchk = 0, nfail = 0;
    int ncmd = 0, run = 0, last_run = 0;
    logic [1:0]  last_op;
    logic [19:0] last_addr;
    logic [15:0] last_data;

    always #4 clk = ~clk;

    flash_cmd_seq i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .supply_ok(supply_ok), .addr(addr), .wdata(wdata), .rd_en(rd_en),
        .array_rdata(array_rdata), .rdata(rdata), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data)
    );

    always @(negedge clk) if (rst_n) begin
        if (cmd_valid) begin
            ncmd++; last_op = cmd_op; last_addr = cmd_addr; last_data = cmd_data;
        end
        if (busy) run++;
        else if (run > 0) begin last_run = run; run = 0; end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [15:0] d, input int lowc,
                      input logic oe_v, input logic sup_v);
        @(negedge clk);
        addr = a; wdata = d; oe_n = oe_v; supply_ok = sup_v; ce_n = 1'b0; we_n = 1'b0;
        repeat (lowc) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (3) @(negedge clk);
        oe_n = 1'b1; supply_ok = 1'b1;
    endtask

    task automatic w(input logic [19:0] a, input logic [15:0] d);
        wr(a, d, 2, 1'b1, 1'b1);
    endtask

    task automatic prog_seq(input logic [19:0] a, input logic [15:0] d);
        w(20'h05555, 16'h00AA); w(20'h02AAA, 16'h0055); w(20'h05555, 16'h00A0); w(a, d);
    endtask

    task automatic erase_seq(input logic [19:0] a, input logic [15:0] code);
        w(20'h05555, 16'h00AA); w(20'h02AAA, 16'h0055); w(20'h05555, 16'h0080);
        w(20'h05555, 16'h00AA); w(20'h02AAA, 16'h0055); w(a, code);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic rd_chk(input logic [15:0] exp, input string req);
        rd_en = 1'b1;
        #1;
        chk(rdata == exp, req, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [15:0] stat(input logic b7, input logic b6);
        return (ARR & 16'hFF3F) | {8'h00, b7, b6, 6'h00};
    endfunction

    task automatic t_reset();
        chk(!cmd_valid && !busy, "R8 reset idle", {busy, cmd_valid}, 0);
        chk(rdata == ARR, "R10 reset read", rdata, ARR);
    endtask

    task automatic t_program();
        int n0 = ncmd;
        prog_seq(20'hABCDE, 16'h3C5A);
        chk(ncmd == n0 + 1, "R1 program accepted", ncmd - n0, 1);
        chk(last_op == 2'd0 && last_addr == 20'hABCDE && last_data == 16'h3C5A,
            "R1 program fields", {last_op, last_addr}, {2'd0, 20'hABCDE});
        rd_chk(stat(1'b1, 1'b0), "R9 R10 first read");
        rd_chk(stat(1'b1, 1'b1), "R10 second read");
        rd_chk(stat(1'b1, 1'b0), "R10 third read");
        wait_idle();
        chk(last_run == PROG_BUSY, "R8 program busy length", last_run, PROG_BUSY);
        chk(rdata == ARR, "R10 true data after busy", rdata, ARR);
    endtask

    task automatic t_erase(input logic [19:0] a, input logic [15:0] code,
                           input logic [1:0] op, input int len);
        int n0 = ncmd;
        erase_seq(a, code);
        chk(ncmd == n0 + 1 && last_op == op && last_addr == a, "R2 erase accepted",
            {ncmd - n0, last_op}, {1, op});
        rd_chk(stat(1'b0, 1'b0), "R9 erase poll bit7 zero");
        wait_idle();
        chk(last_run == len, "R8 erase busy length", last_run, len);
    endtask

    task automatic t_abort();
        int n0 = ncmd;
        w(20'h05555, 16'h00AA); w(20'h01111, 16'h0055);
        w(20'h05555, 16'h00A0); w(20'h00100, 16'h1111);
        chk(ncmd == n0, "R3 abort on bad address", ncmd - n0, 0);
        w(20'h05555, 16'h00AA); w(20'h02AAA, 16'h0055); w(20'h05555, 16'h0080);
        w(20'h05555, 16'h0077); w(20'h02AAA, 16'h0055); w(20'h05555, 16'h0010);
        chk(ncmd == n0, "R3 abort inside erase", ncmd - n0, 0);
        prog_seq(20'h00200, 16'h0080);
        chk(ncmd == n0 + 1 && last_addr == 20'h00200, "R3 recovery after abort",
            ncmd - n0, 1);
        rd_chk(stat(1'b0, 1'b0), "R9 inverted bit7 one");
        wait_idle();
    endtask

    task automatic t_inhibit();
        int n0 = ncmd;
        wr(20'h05555, 16'h00AA, 2, 1'b0, 1'b1); wr(20'h02AAA, 16'h0055, 2, 1'b0, 1'b1);
        wr(20'h05555, 16'h00A0, 2, 1'b0, 1'b1); wr(20'h00300, 16'h0001, 2, 1'b0, 1'b1);
        chk(ncmd == n0, "R4 oe low inhibits", ncmd - n0, 0);
        @(negedge clk); ce_n = 1'b0; addr = 20'h05555; wdata = 16'h00AA;
        repeat (3) @(negedge clk); ce_n = 1'b1; repeat (3) @(negedge clk);
        w(20'h02AAA, 16'h0055); w(20'h05555, 16'h00A0); w(20'h00300, 16'h0001);
        chk(ncmd == n0, "R4 we high inhibits", ncmd - n0, 0);
    endtask

    task automatic t_glitch();
        int n0 = ncmd;
        w(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055, 1, 1'b1, 1'b1);
        w(20'h05555, 16'h00A0); w(20'h00400, 16'h0002);
        chk(ncmd == n0, "R5 short strobe rejected", ncmd - n0, 0);
        w(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055, 5, 1'b1, 1'b1);
        w(20'h05555, 16'h00A0); w(20'h00400, 16'h0002);
        chk(ncmd == n0 + 1, "R5 long strobe accepted", ncmd - n0, 1);
        wait_idle();
    endtask

    task automatic t_supply();
        int n0 = ncmd;
        wr(20'h05555, 16'h00AA, 2, 1'b1, 1'b0);
        w(20'h02AAA, 16'h0055); w(20'h05555, 16'h00A0); w(20'h00500, 16'h0003);
        chk(ncmd == n0, "R6 low supply blocks", ncmd - n0, 0);
    endtask

    task automatic t_highbyte();
        int n0 = ncmd;
        w(20'h05555, 16'hFFAA); w(20'h02AAA, 16'h3C55); w(20'h05555, 16'h81A0);
        w(20'h00600, 16'hBEEF);
        chk(ncmd == n0 + 1 && last_data == 16'hBEEF, "R7 high byte ignored",
            last_data, 16'hBEEF);
        prog_seq(20'h00700, 16'h1234);
        chk(ncmd == n0 + 1, "R8 writes ignored while busy", ncmd - n0, 1);
        wait_idle();
        prog_seq(20'h00800, 16'h4321);
        chk(ncmd == n0 + 2 && last_addr == 20'h00800, "R8 accepts after busy",
            ncmd - n0, 2);
        wait_idle();
    endtask

    initial begin
        #400000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase(20'h05555, 16'h0010, 2'd3, CHIP_BUSY);
        t_erase(20'h12345, 16'hFF30, 2'd1, SECT_BUSY);
        t_erase(20'h0F000, 16'h0050, 2'd2, BLK_BUSY);
        t_abort();
        t_inhibit();
        t_glitch();
        t_supply();
        t_highbyte();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule